// File: doc/BRIEF.md
# Multi-Mode DCO Frequency Controller

This block is the oscillator stage of a per-port digital clock-recovery loop. It runs from the master clock and holds a phase accumulator. The most significant bit of the accumulator is the recovered output clock. On every master-clock cycle the accumulator adds a frequency word. That word is the nominal step for the selected output rate plus a signed, range-limited offset.

A two-bit sub-mode input chooses where the offset comes from:
- the loop-filter output (tracking);
- a value frozen from the last tracking cycle (holdover);
- zero (freerun);
- a difference register written by software (CPU-in-the-loop).

Loss of signal on a port that carries unstructured data forces holdover, whatever the sub-mode input says. Software can read back the filter output through a registered port and close the loop itself by writing the difference register.

The nominal steps are rounded values of f·2^32/66 MHz:
- 100476205 for 1.544 MHz;
- 133274137 for 2.048 MHz;
- 266548273 for 4.096 MHz.

One step LSB is well under 0.1 ppm. The offset clamp is floor(nominal·250/10^6), which gives about ±250 ppm.

Top module: `dco_freq_ctrl`

## Requirements
- R1: While rst_ni is low, freq_word_o, dco_clk_o and cpu_filt_o are all zero.
- R2: Sub-mode 2'b00 (tracking): one cycle after an edge, freq_word_o equals nominal + clamp(filt_ofs_i), using the values sampled at that edge.
- R3: Sub-mode 2'b01 (holdover): filt_ofs_i has no effect. freq_word_o equals nominal + the clamped offset of the last tracking cycle.
- R4: When los_i and udt_i are both high, the block behaves as holdover whatever mode_sel_i says. los_i alone, with udt_i low, has no effect. After los_i drops, the sub-mode from mode_sel_i applies from the next edge.
- R5: Sub-mode 2'b10 (freerun): freq_word_o equals exactly the nominal step, whatever filt_ofs_i is.
- R6: Sub-mode 2'b11 (CPU): freq_word_o equals nominal + clamp(difference register). The difference register is loaded from cpu_wdata_i at each edge where cpu_we_i is high.
- R7: cpu_filt_o shows filt_ofs_i as sampled at the previous edge, in every sub-mode.
- R8: freq_sel_i chooses the nominal step:
  - 2'b00 selects 100476205 (1.544 MHz);
  - 2'b01 selects 133274137 (2.048 MHz);
  - 2'b10 and 2'b11 select 266548273 (4.096 MHz).
- R9: Offsets are clamped to ±L before use, where L is 25119, 33318 or 66637 for the three rates.
- R10: The accumulator adds the frequency word held in the previous cycle at every edge, wrapping at 32 bits. dco_clk_o is its bit 31.
- R11: The holdover value is loaded only on edges where the effective sub-mode is tracking. Freerun, CPU and holdover edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 2 | Sub-mode: 0 tracking, 1 holdover, 2 freerun, 3 CPU |
| freq_sel_i | input | 2 | Nominal rate select |
| los_i | input | 1 | Loss of signal on the port |
| udt_i | input | 1 | Port runs unstructured data transfer |
| filt_ofs_i | input | 20 | Signed loop-filter offset |
| cpu_we_i | input | 1 | Difference register write strobe |
| cpu_wdata_i | input | 20 | Signed difference value to write |
| cpu_filt_o | output | 20 | Registered filter offset readback |
| freq_word_o | output | 32 | Current accumulator increment |
| dco_clk_o | output | 1 | Recovered clock (accumulator MSB) |

## Verification
The assertions rely on filt_ofs_i and cpu_wdata_i being signed values that fit the 20-bit width. Any of them may exceed the clamp. They also rely on mode_sel_i, freq_sel_i, los_i and udt_i being steady around each rising edge. The freerun check further assumes that the rate chosen at one edge defines the nominal step in the next cycle.

All stimulus changes on the falling edge. Offsets are drawn both inside and well outside the clamp, and write data stays within the signed 20-bit range. The loss-of-signal flag is toggled in every sub-mode, with and without the unstructured-data flag.

// File: rtl/dco_pkg.sv
package dco_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_FREE = 2'd2,
    MODE_CPU  = 2'd3
  } dco_mode_e;

  // rounded f * 2^acc_w / mclk
  function automatic longint nom_step(longint f_hz, longint mclk_hz, int acc_w);
    return ((f_hz << acc_w) + mclk_hz / 2) / mclk_hz;
  endfunction
endpackage

// File: rtl/dco_mode_ctrl.sv
module dco_mode_ctrl
  import dco_pkg::*;
(
  input  logic [1:0] mode_sel_i,
  input  logic       los_i,
  input  logic       udt_i,
  output dco_mode_e  eff_mode_o
);
  always_comb begin
    if (los_i && udt_i) eff_mode_o = MODE_HOLD;
    else                eff_mode_o = dco_mode_e'(mode_sel_i);
  end
endmodule

// File: rtl/dco_cpu_regs.sv
module dco_cpu_regs #(
  parameter int OFS_W = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic signed [OFS_W-1:0] wdata_i,
  input  logic signed [OFS_W-1:0] filt_i,
  output logic signed [OFS_W-1:0] diff_o,
  output logic signed [OFS_W-1:0] filt_rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diff_o    <= '0;
      filt_rd_o <= '0;
    end else begin
      if (we_i) diff_o <= wdata_i;
      filt_rd_o <= filt_i;
    end
  end
endmodule

// File: rtl/dco_offset_sel.sv
module dco_offset_sel
  import dco_pkg::*;
#(
  parameter int OFS_W = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  dco_mode_e               eff_mode_i,
  input  logic signed [OFS_W-1:0] filt_i,
  input  logic signed [OFS_W-1:0] diff_i,
  input  logic        [OFS_W-1:0] lim_i,
  output logic signed [OFS_W-1:0] ofs_o
);
  logic signed [OFS_W-1:0] filt_sat, diff_sat, hold_q;

  function automatic logic signed [OFS_W-1:0] clamp(
      input logic signed [OFS_W-1:0] x, input logic [OFS_W-1:0] lim);
    logic signed [OFS_W:0] xe, lp;
    xe = OFS_W'(x);
    xe = {x[OFS_W-1], x};
    lp = $signed({1'b0, lim});
    if (xe > lp)       return lim;
    else if (xe < -lp) return OFS_W'(-lp);
    else               return x;
  endfunction

  assign filt_sat = clamp(filt_i, lim_i);
  assign diff_sat = clamp(diff_i, lim_i);

  always_comb begin
    unique case (eff_mode_i)
      MODE_NORM: ofs_o = filt_sat;
      MODE_HOLD: ofs_o = hold_q;
      MODE_FREE: ofs_o = '0;
      default:   ofs_o = diff_sat;
    endcase
  end

  // holdover snapshot follows tracking only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= '0;
    else if (eff_mode_i == MODE_NORM) hold_q <= filt_sat;
  end

  a_r11_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_mode_i != MODE_NORM) |=> $stable(hold_q));

  a_r9_ofs_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed({ofs_o[OFS_W-1], ofs_o}) <= $signed({1'b0, lim_i})) &&
    ($signed({ofs_o[OFS_W-1], ofs_o}) >= -$signed({1'b0, lim_i})));
endmodule

// File: rtl/dco_phase_acc.sv
module dco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic        [ACC_W-1:0] nom_i,
  input  logic signed [OFS_W-1:0] ofs_i,
  output logic        [ACC_W-1:0] fw_o,
  output logic                    clk_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fw_o  <= '0;
      acc_q <= '0;
    end else begin
      fw_o  <= nom_i + {{(ACC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
      acc_q <= acc_q + fw_o;
    end
  end

  assign clk_o = acc_q[ACC_W-1];
endmodule

// File: rtl/dco_freq_ctrl.sv
module dco_freq_ctrl
  import dco_pkg::*;
#(
  parameter int     ACC_W   = 32,
  parameter int     OFS_W   = 20,
  parameter longint MCLK_HZ = 66000000,
  parameter longint F0_HZ   = 1544000,
  parameter longint F1_HZ   = 2048000,
  parameter longint F2_HZ   = 4096000,
  parameter longint PPM_LIM = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_sel_i,
  input  logic [1:0]       freq_sel_i,
  input  logic             los_i,
  input  logic             udt_i,
  input  logic [OFS_W-1:0] filt_ofs_i,
  input  logic             cpu_we_i,
  input  logic [OFS_W-1:0] cpu_wdata_i,
  output logic [OFS_W-1:0] cpu_filt_o,
  output logic [ACC_W-1:0] freq_word_o,
  output logic             dco_clk_o
);
  localparam int N_RATES = 3;
  localparam longint RATE_HZ [N_RATES] = '{F0_HZ, F1_HZ, F2_HZ};

  logic [ACC_W-1:0] nom_tab [N_RATES];
  logic [OFS_W-1:0] lim_tab [N_RATES];

  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    localparam longint NOM = nom_step(RATE_HZ[g], MCLK_HZ, ACC_W);
    localparam longint LIM = NOM * PPM_LIM / 1000000;
    assign nom_tab[g] = NOM[ACC_W-1:0];
    assign lim_tab[g] = LIM[OFS_W-1:0];
  end

  logic [1:0]              rate_idx;
  logic [ACC_W-1:0]        nom_sel;
  logic [OFS_W-1:0]        lim_sel;
  dco_mode_e               eff_mode;
  logic signed [OFS_W-1:0] diff_q, ofs_app;

  assign rate_idx = freq_sel_i[1] ? 2'd2 : {1'b0, freq_sel_i[0]};
  assign nom_sel  = nom_tab[rate_idx];
  assign lim_sel  = lim_tab[rate_idx];

  dco_mode_ctrl u_mode (
    .mode_sel_i (mode_sel_i),
    .los_i      (los_i),
    .udt_i      (udt_i),
    .eff_mode_o (eff_mode)
  );

  dco_cpu_regs #(.OFS_W(OFS_W)) u_cpu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cpu_we_i),
    .wdata_i   ($signed(cpu_wdata_i)),
    .filt_i    ($signed(filt_ofs_i)),
    .diff_o    (diff_q),
    .filt_rd_o (cpu_filt_o)
  );

  dco_offset_sel #(.OFS_W(OFS_W)) u_ofs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eff_mode_i (eff_mode),
    .filt_i     ($signed(filt_ofs_i)),
    .diff_i     (diff_q),
    .lim_i      (lim_sel),
    .ofs_o      (ofs_app)
  );

  dco_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nom_i  (nom_sel),
    .ofs_i  (ofs_app),
    .fw_o   (freq_word_o),
    .clk_o  (dco_clk_o)
  );

  a_r4_los_forces_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_i && udt_i) |-> (eff_mode == MODE_HOLD));

  a_r5_freerun_nominal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_mode == MODE_FREE) |=> (freq_word_o == $past(nom_sel)));

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (freq_word_o == '0 && !dco_clk_o));
endmodule

// File: tb/dco_freq_ctrl_test.sv
module dco_freq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_sel = 2'd0, freq_sel = 2'd0;
  logic        los = 1'b0, udt = 1'b0, cpu_we = 1'b0;
  logic signed [19:0] filt = '0, wdata = '0;
  logic [19:0] cpu_filt;
  logic [31:0] fw;
  logic        dclk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  int m_hold = 0, m_diff = 0, m_filt = 0, m_last_mode = 0;
  bit [31:0] m_fw = 0, m_acc = 0;

  always #10 clk = ~clk;

  dco_freq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_sel_i(mode_sel), .freq_sel_i(freq_sel),
    .los_i(los), .udt_i(udt), .filt_ofs_i(filt), .cpu_we_i(cpu_we),
    .cpu_wdata_i(wdata), .cpu_filt_o(cpu_filt), .freq_word_o(fw), .dco_clk_o(dclk)
  );

  function automatic int nomv(int fs);
    case (fs)
      0: return 100476205;
      1: return 133274137;
      default: return 266548273;
    endcase
  endfunction

  function automatic int limv(int fs);
    case (fs)
      0: return 25119;
      1: return 33318;
      default: return 66637;
    endcase
  endfunction

  function automatic int sat(int x, int l);
    if (x > l) return l;
    if (x < -l) return -l;
    return x;
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int eff, fs, l, app, fsat;
    fs   = int'(freq_sel);
    l    = limv(fs);
    eff  = (los && udt) ? 1 : int'(mode_sel);
    fsat = sat(int'(filt), l);
    case (eff)
      0: app = fsat;
      1: app = m_hold;
      2: app = 0;
      default: app = sat(m_diff, l);
    endcase
    m_acc = m_acc + m_fw;
    m_fw  = 32'(nomv(fs) + app);
    if (eff == 0) m_hold = fsat;
    if (cpu_we) m_diff = int'(wdata);
    m_filt = int'(filt);
    m_last_mode = eff;
  endtask

  task automatic compare();
    string t;
    t = mode_tag(m_last_mode);
    if (los && udt) t = {t, "/R4"};
    check(fw == m_fw, t, fw, m_fw);
    check(dclk == m_acc[31], "R10", dclk, m_acc[31]);
    check($signed(cpu_filt) == m_filt, "R7", $signed(cpu_filt), m_filt);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n, int span);
    for (int i = 0; i < n; i++) begin
      if (span > 0) filt = 20'($signed($urandom_range(2 * span)) - span);
      tick();
    end
  endtask

  task automatic cpu_write(int v);
    cpu_we = 1'b1; wdata = 20'(v);
    tick();
    cpu_we = 1'b0;
  endtask

  initial begin
    bit [31:0] snap;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(fw == 0, "R1", fw, 0);
    check(dclk == 0, "R1", dclk, 0);
    check(cpu_filt == 0, "R1", cpu_filt, 0);
    rst_ni = 1'b1;

    // R2/R10: tracking at each rate
    run(200, 20000);
    filt = 20'sd400000; tick();
    check(fw == 32'(100476205 + 25119), "R9", fw, 100476205 + 25119);
    filt = -20'sd400000; tick();
    check(fw == 32'(100476205 - 25119), "R9", fw, 100476205 - 25119);
    freq_sel = 2'd1; run(100, 60000);
    freq_sel = 2'd2; run(100, 100000);
    freq_sel = 2'd3; filt = 0; tick();
    check(fw == 32'd266548273, "R8", fw, 266548273);
    freq_sel = 2'd1; filt = 20'sd70000; tick();
    check(fw == 32'(133274137 + 33318), "R9", fw, 133274137 + 33318);

    // R3: holdover ignores input
    snap = fw;
    mode_sel = 2'd1; run(150, 200000);
    check(fw == snap, "R3", fw, snap);

    // R5: freerun
    mode_sel = 2'd0; run(50, 30000);
    mode_sel = 2'd2; run(100, 200000);
    check(fw == 32'd133274137, "R5", fw, 133274137);

    // R6: CPU difference register
    mode_sel = 2'd3;
    cpu_write(1234); run(30, 200000);
    cpu_write(500000); run(20, 0);
    check(fw == 32'(133274137 + 33318), "R6", fw, 133274137 + 33318);
    cpu_write(-500000); run(20, 0);
    check(fw == 32'(133274137 - 33318), "R6", fw, 133274137 - 33318);
    cpu_write(-777); run(20, 5000);

    // R4: loss of signal
    mode_sel = 2'd0; freq_sel = 2'd0; run(40, 20000);
    los = 1'b1; udt = 1'b0; run(50, 20000);
    udt = 1'b1; snap = fw; run(50, 200000);
    check(fw == snap, "R4", fw, snap);
    mode_sel = 2'd3; run(30, 200000);
    mode_sel = 2'd2; run(30, 200000);
    check(fw == snap, "R11", fw, snap);
    los = 1'b0; run(20, 20000);
    mode_sel = 2'd1; run(20, 20000);
    mode_sel = 2'd0; run(30, 20000);
    los = 1'b1; tick(); los = 1'b0; run(30, 20000);
    freq_sel = 2'd2; mode_sel = 2'd3; run(60, 20000);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule